// File: doc/BRIEF.md
# Two-Channel Serial Audio Transmitter (DSP Late Alignment)

This block takes a stereo pair of parallel sample words and sends them MSB first on one serial data line, in DSP late-alignment framing. An external bit clock and a frame-sync pulse arrive as plain synchronous inputs. The block runs on a faster system clock and watches both signals there. A falling bit-clock edge is seen as a clock cycle in which the bit clock is low after being high one cycle earlier. Each such falling edge is a "bit step", and on a bit step the serial output and the busy flag may change.

A frame starts on a bit step at which frame sync reads high, if frame sync read low at the previous bit step. At that step the block captures both sample words and the word-length setting, and it drives the left MSB at once. On each later bit step the next bit goes out. The right word starts with no gap directly after the left LSB. Once the right LSB has been shown, the line is held at 0 and busy is low until the next frame start.

A receiver samples the line on rising bit-clock edges. The host may rewrite the sample inputs at any time, because only the frame-start step reads them.

Top module: `dsp_late_tx`

## Requirements
- R1: While `rst` is high at a clock edge, that edge sets `sdata_o` and `busy_o` to 0.
- R2: On a frame-start step, both `sdata_o` and `busy_o` update at that clock edge. `sdata_o` takes bit 31 of `left_i` and `busy_o` goes to 1. A frame-start step is a bit step at which `fsync_i` is 1, where `fsync_i` was 0 at the previous bit step, or 0 since reset.
- R3: `sdata_o` and `busy_o` change only at the clock edge of a bit step. A bit step is a clock edge at which `bclk_i` is 0 and was 1 at the previous clock edge.
- R4: After the frame-start step, the next n−1 bit steps drive bits 30 down to 32−n of the captured left word, one per step. So the left word goes out MSB first as its top n bits.
- R5: The n bit steps right after the left LSB drive bits 31 down to 32−n of the captured right word, with no step between the two words.
- R6: `wlen_i` sets n at the frame-start step: 2'b00 gives 16, 2'b01 gives 20, 2'b10 gives 24 and 2'b11 gives 32. Changes to `wlen_i` during the frame have no effect on that frame.
- R7: `left_i` and `right_i` are read only at the frame-start step. Changing them during a frame does not change the bits that frame sends.
- R8: `busy_o` is 1 while `sdata_o` shows a valid bit. From the first bit step after the right LSB until the next frame start, `sdata_o` is 0 and `busy_o` is 0.
- R9: If `fsync_i` stays high over several bit steps, only the first of them starts a frame. A new frame start that arrives during a frame, or at the step where the frame would go idle, wins and starts the new frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Bit clock, synchronous to `clk` |
| fsync_i | input | 1 | Frame sync, changes with bit-clock falls |
| wlen_i | input | 2 | Word-length select (16/20/24/32) |
| left_i | input | 32 | Left sample word, MSB-aligned |
| right_i | input | 32 | Right sample word, MSB-aligned |
| sdata_o | output | 1 | Serial data line |
| busy_o | output | 1 | High while a valid bit is shown |

## Verification
A frame start can fall on the same bit step at which the sequencer would otherwise send its last valid bit, or drop to idle. A start can also arrive partway through a frame. The bench provokes the first case with a frame whose length is exactly 2n bit periods, so the next sync pulse hits the step that would end the frame. It provokes the second case by cutting a frame short after a few bits. In both cases the reference model requires the new left MSB and a busy flag that stays high, with no idle zero in between.

// File: rtl/dsp_tx_pkg.sv
package dsp_tx_pkg;

    // Word-length codes as seen on the configuration input
    typedef enum logic [1:0] {
        WL_16 = 2'b00,
        WL_20 = 2'b01,
        WL_24 = 2'b10,
        WL_32 = 2'b11
    } wlen_e;

    // What the sequencer asks the shifter to do on this clock
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LOAD,
        ST_LEFT,
        ST_RIGHT,
        ST_IDLE
    } step_e;

    // Events derived from the sampled bit clock and frame sync
    typedef struct packed {
        logic fall;
        logic start;
    } bclk_evt_t;

    function automatic int unsigned wlen_bits(wlen_e w);
        case (w)
            WL_16:   return 16;
            WL_20:   return 20;
            WL_24:   return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/ser_evt_det.sv
module ser_evt_det
    import dsp_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bclk,
    input  logic      fsync,
    output bclk_evt_t evt
);
    logic bclk_q;
    logic fs_at_fall;

    always_comb begin
        evt.fall  = bclk_q & ~bclk;
        evt.start = evt.fall & fsync & ~fs_at_fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q     <= 1'b0;
            fs_at_fall <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (evt.fall)
                fs_at_fall <= fsync;
        end
    end

    // R9
    held_sync_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !evt.start);

endmodule

// File: rtl/ser_seq.sv
module ser_seq
    import dsp_tx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  bclk_evt_t evt,
    input  wlen_e     wlen,
    output step_e     step,
    output logic      busy
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nlen;
    logic [CNT_W-1:0] flen;

    assign flen = nlen << 1;

    always_comb begin
        if (!evt.fall)
            step = ST_HOLD;
        else if (evt.start)
            step = ST_LOAD;
        else if (cnt < nlen)
            step = ST_LEFT;
        else if (cnt < flen)
            step = ST_RIGHT;
        else
            step = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            nlen <= '0;
            busy <= 1'b0;
        end else begin
            case (step)
                ST_LOAD: begin
                    cnt  <= CNT_W'(1);
                    nlen <= CNT_W'(wlen_bits(wlen));
                    busy <= 1'b1;
                end
                ST_LEFT, ST_RIGHT: begin
                    cnt  <= cnt + CNT_W'(1);
                    busy <= 1'b1;
                end
                ST_IDLE: busy <= 1'b0;
                default: ;
            endcase
        end
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= flen);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> busy);

endmodule

// File: rtl/ser_shift.sv
module ser_shift
    import dsp_tx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  step_e        step,
    input  logic [W-1:0] left,
    input  logic [W-1:0] right,
    output logic         dout
);
    logic [W-1:0] lsr;
    logic [W-1:0] rsr;

    always_ff @(posedge clk) begin
        if (rst) begin
            lsr  <= '0;
            rsr  <= '0;
            dout <= 1'b0;
        end else begin
            case (step)
                ST_LOAD: begin
                    dout <= left[W-1];
                    lsr  <= left << 1;
                    rsr  <= right;
                end
                ST_LEFT: begin
                    dout <= lsr[W-1];
                    lsr  <= lsr << 1;
                end
                ST_RIGHT: begin
                    dout <= rsr[W-1];
                    rsr  <= rsr << 1;
                end
                ST_IDLE: dout <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dsp_late_tx.sv
module dsp_late_tx
    import dsp_tx_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_i,
    input  logic                fsync_i,
    input  logic [1:0]          wlen_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                sdata_o,
    output logic                busy_o
);
    localparam int CNT_W = $clog2(2 * SAMPLE_W + 1);

    bclk_evt_t evt;
    step_e     step;

    ser_evt_det u_evt (
        .clk   (clk),
        .rst   (rst),
        .bclk  (bclk_i),
        .fsync (fsync_i),
        .evt   (evt)
    );

    ser_seq #(.CNT_W(CNT_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .wlen (wlen_e'(wlen_i)),
        .step (step),
        .busy (busy_o)
    );

    ser_shift #(.W(SAMPLE_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .left  (left_i),
        .right (right_i),
        .dout  (sdata_o)
    );

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !sdata_o);

    // R3
    hold_between_steps_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.fall |=> ($stable(sdata_o) && $stable(busy_o)));

    // R2
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (sdata_o == $past(left_i[SAMPLE_W-1])));

endmodule

// File: tb/tb_dsp_late_tx.sv
module tb_dsp_late_tx;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic [1:0]  wl = 2'b00;
    logic [31:0] left = '0;
    logic [31:0] right = '0;
    logic        sdata, busy;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit started = 0;

    always #2 clk = ~clk;

    dsp_late_tx dut (
        .clk(clk), .rst(rst), .bclk_i(bclk), .fsync_i(fsync),
        .wlen_i(wl), .left_i(left), .right_i(right),
        .sdata_o(sdata), .busy_o(busy)
    );

    // Behavioural reference: a queue of pending bits
    bit    q[$];
    bit    bq = 0, fsp = 0;
    bit    exp_d = 0, exp_b = 0;
    int    nsent = 0, nlen = 0;
    string tag = "R1";

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            q.delete(); bq = 0; fsp = 0; exp_d = 0; exp_b = 0;
            nsent = 0; nlen = 0; tag = "R1";
        end else begin
            if (bq && !bclk) begin
                if (fsync && !fsp) begin
                    // R6: length chosen from code at frame start
                    case (wl)
                        2'b00: nlen = 16;
                        2'b01: nlen = 20;
                        2'b10: nlen = 24;
                        default: nlen = 32;
                    endcase
                    q.delete();
                    for (int i = 0; i < nlen; i++) q.push_back(left[31-i]);
                    for (int i = 0; i < nlen; i++) q.push_back(right[31-i]);
                    exp_d = q.pop_front(); exp_b = 1; nsent = 1; tag = "R2";
                end else if (q.size() > 0) begin
                    exp_d = q.pop_front(); exp_b = 1; nsent++;
                    tag = (nsent <= nlen) ? "R4" : "R5";
                end else begin
                    exp_d = 0; exp_b = 0; tag = "R8";
                end
                fsp = fsync;
            end else if (tag != "R1") begin
                tag = "R3";
            end
            bq = bclk;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            tests++;
            if (sdata !== exp_d || busy !== exp_b) begin
                fails++;
                $display("FAIL %s: sdata=%b busy=%b expected sdata=%b busy=%b at %0t",
                         tag, sdata, busy, exp_d, exp_b, $time);
            end
        end
    end

    task automatic period(input logic fs);
        @(negedge clk) bclk = 1'b1;
        repeat (H - 1) @(negedge clk);
        @(negedge clk) begin bclk = 1'b0; fsync = fs; end
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] l, input logic [31:0] r,
                         input logic [1:0] w, input int p, input int fslen,
                         input bit mid);
        @(negedge clk) begin left = l; right = r; wl = w; end
        for (int k = 0; k < p; k++) begin
            if (mid && k == 3) begin
                left = ~l; right = ~r; wl = ~w;   // R7 and R6: ignored mid-frame
            end
            period(k < fslen);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);   // R1 checked during reset
        rst = 1'b0;
        repeat (3) period(1'b0);
        // R4 R5 R8: 16-bit words then idle tail
        frame(32'hA5C3_1F0E, 32'h5A3C_E0F1, 2'b00, 36, 1, 0);
        // R7 R6 R9: held sync, inputs changed mid-frame
        frame(32'h8123_4567, 32'hFEDC_BA98, 2'b01, 44, 3, 1);
        // R9: next start lands on the step that would go idle (2n periods)
        frame(32'hC0FF_EE11, 32'h1357_9BDF, 2'b10, 48, 1, 0);
        // R9: restart mid-frame
        frame(32'h7FFF_0001, 32'h8000_FFFE, 2'b11, 20, 1, 0);
        // R4 R5: full 32-bit words
        frame(32'hDEAD_BEEF, 32'h0BAD_F00D, 2'b11, 70, 1, 0);
        // R8: all-ones words, then idle
        frame(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 34, 1, 0);
        repeat (4) period(1'b0);
        // R1: reset mid-operation
        frame(32'h1234_5678, 32'h9ABC_DEF0, 2'b10, 10, 1, 0);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) period(1'b0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule